// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block handles tag lookup and line replacement for an 8-way set-associative cache. The cache has 64 sets and 64-byte lines and works on 36-bit physical addresses. It holds the tag, valid and dirty state of every line and a per-set array of age counters. It does not hold the line data. The requester presents one read or write at a time on a valid/ready port. A hit is reported one cycle after the request is accepted, together with the matching way.

On a miss the controller picks a victim way. An empty way is taken first. When every way is valid, the way with the oldest age counter is taken. If the victim holds modified data, the controller first asks the next level to write it back and waits for the acknowledge. It then asks the next level to fill the line, and reports the miss with the chosen way when the fill is acknowledged. Writes are handled write-back: a write only marks the cached line modified.

Top module: `cache_tag_ctrl`

## Requirements
- R1: An address splits into tag = bits [35:12], set index = bits [11:6] and byte offset = bits [5:0]. The offset has no effect on lookup. Addresses that differ by a multiple of 4096 select the same set.
- R2: A request is a hit when a valid way of the indexed set holds the request tag. In the cycle after acceptance the block then drives resp_valid_o=1, resp_hit_o=1 and resp_way_o set to that way. On a miss, resp_valid_o stays 0 in that cycle.
- R3: On a miss, if any way of the set is invalid, the victim is the invalid way with the lowest index.
- R4: Each way has a 3-bit age. An access (a hit, or a line install) sets the accessed way's age to 0 and adds one to every way whose age was lower, saturating at 7. When all ways are valid, the victim is the way with the highest age.
- R5: A write hit marks the line dirty. A write miss installs the line as dirty. A read never marks a line dirty.
- R6: When the victim is valid and dirty, wb_valid_o rises with wb_tag_o set to the victim's tag and wb_index_o set to the set index. It stays high and stable until wb_ack_i. fill_valid_o stays 0 until the cycle after the acknowledge.
- R7: When the victim is clean or invalid, fill_valid_o rises directly after lookup, with fill_tag_o and fill_index_o taken from the request. It stays high until fill_ack_i. In the acknowledge cycle the block drives resp_valid_o=1, resp_hit_o=0 and resp_way_o set to the victim, and the line is installed.
- R8: req_ready_o is 1 only while the controller is idle, so a request is accepted only after the previous one has completed.
- R9: Reset makes every line invalid and clean and sets the age of way i to i in every set. It leaves req_ready_o=1 and resp_valid_o, wb_valid_o and fill_valid_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_addr_i | input | 36 | Request physical address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| resp_valid_o | output | 1 | Response strobe |
| resp_hit_o | output | 1 | 1 = hit, 0 = miss |
| resp_way_o | output | 3 | Hit way or installed victim way |
| wb_valid_o | output | 1 | Write-back request to the next level |
| wb_ack_i | input | 1 | Write-back acknowledge |
| wb_tag_o | output | 24 | Tag of the line to write back |
| wb_index_o | output | 6 | Set of the line to write back |
| fill_valid_o | output | 1 | Line fill request to the next level |
| fill_ack_i | input | 1 | Fill acknowledge |
| fill_tag_o | output | 24 | Tag of the line to fill |
| fill_index_o | output | 6 | Set of the line to fill |

## Verification
The bench fills one set through 4096-byte aliases and checks that empty ways are taken in index order. It then checks that a hit in the middle of the age order protects its way from the next eviction. A design with a wrong age update would evict the way just hit, and one that looked at offset bits would miss on an offset-changed re-access. The bench also checks that a line made dirty by a write hit, or installed by a write miss, comes back later as a write-back with its own tag. A design that ignored dirty state would skip straight to the fill, and one that fetched too early would raise the fill while the write-back was still unacknowledged. Finally, a second reset must turn a previously resident tag into a miss placed in way 0.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL
  } ctrl_state_e;
endpackage

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
  parameter int TAG_W = 24,
  parameter int WAYS  = 8,
  parameter int SETS  = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            set_i,
  input  logic                        install_i,
  input  logic [WAY_W-1:0]            install_way_i,
  input  logic [TAG_W-1:0]            install_tag_i,
  input  logic                        install_dirty_i,
  input  logic                        mark_dirty_i,
  input  logic [WAY_W-1:0]            mark_way_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0]             rd_valid_o,
  output logic [WAYS-1:0]             rd_dirty_o
);
  logic [TAG_W-1:0] tag_mem   [SETS][WAYS];
  logic [WAYS-1:0]  valid_mem [SETS];
  logic [WAYS-1:0]  dirty_mem [SETS];

  // tags carry no reset; valid gates their use
  always_ff @(posedge clk_i) begin
    if (install_i) tag_mem[set_i][install_way_i] <= install_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_mem[s] <= '0;
        dirty_mem[s] <= '0;
      end
    end else if (install_i) begin
      valid_mem[set_i][install_way_i] <= 1'b1;
      dirty_mem[set_i][install_way_i] <= install_dirty_i;
    end else if (mark_dirty_i) begin
      dirty_mem[set_i][mark_way_i] <= 1'b1;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag_o[w] = tag_mem[set_i][w];
  end
  assign rd_valid_o = valid_mem[set_i];
  assign rd_dirty_o = dirty_mem[set_i];
endmodule

// File: rtl/cache_age_array.sv
module cache_age_array #(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int AGE_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            set_i,
  input  logic                        touch_i,
  input  logic [AGE_W-1:0]            touch_way_i,
  output logic [WAYS-1:0][AGE_W-1:0]  age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [WAYS-1:0][AGE_W-1:0] age_mem [SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_nxt;

  assign age_o = age_mem[set_i];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == touch_way_i)
        age_nxt[w] = '0;
      else if (age_o[w] < age_o[touch_way_i] && age_o[w] != AGE_MAX)
        age_nxt[w] = age_o[w] + 1'b1;
      else
        age_nxt[w] = age_o[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_mem[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      age_mem[set_i] <= age_nxt;
    end
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int WAYS = 8,
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0]  age_i,
  output logic [AGE_W-1:0]            victim_o
);
  logic             any_free;
  logic [AGE_W-1:0] free_way;
  logic [AGE_W-1:0] old_way;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_way = AGE_W'(i);
      end
    end
    old_way = '0;
    old_age = age_i[0];
    for (int i = 1; i < WAYS; i++) begin
      if (age_i[i] > old_age) begin
        old_age = age_i[i];
        old_way = AGE_W'(i);
      end
    end
    victim_o = any_free ? free_way : old_way;
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int ADDR_W = 36,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 6,
  parameter int WAYS   = 8,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              wb_valid_o,
  input  logic              wb_ack_i,
  output logic [TAG_W-1:0]  wb_tag_o,
  output logic [IDX_W-1:0]  wb_index_o,
  output logic              fill_valid_o,
  input  logic              fill_ack_i,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [IDX_W-1:0]  fill_index_o
);
  import cache_tag_pkg::*;

  ctrl_state_e      state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             write_q;
  logic [WAY_W-1:0] victim_q;

  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0]            rd_dirty;
  logic [WAYS-1:0][WAY_W-1:0] ages;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           victim;
  logic                       in_lookup;
  logic                       install;
  logic                       accept;
  logic                       unused_offset;

  assign unused_offset = ^req_addr_i[OFF_W-1:0];
  assign accept        = req_valid_i && req_ready_o;
  assign in_lookup     = state_q == ST_LOOKUP;
  assign install       = state_q == ST_FILL && fill_ack_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && rd_tag[w] == tag_q;
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  cache_tag_array #(.TAG_W(TAG_W), .WAYS(WAYS), .SETS(SETS)) u_tags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .set_i           (idx_q),
    .install_i       (install),
    .install_way_i   (victim_q),
    .install_tag_i   (tag_q),
    .install_dirty_i (write_q),
    .mark_dirty_i    (in_lookup && hit && write_q),
    .mark_way_i      (hit_way),
    .rd_tag_o        (rd_tag),
    .rd_valid_o      (rd_valid),
    .rd_dirty_o      (rd_dirty)
  );

  cache_age_array #(.WAYS(WAYS), .SETS(SETS)) u_ages (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (idx_q),
    .touch_i     (resp_valid_o),
    .touch_way_i (resp_way_o),
    .age_o       (ages)
  );

  cache_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i  (rd_valid),
    .age_i    (ages),
    .victim_o (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tag_q    <= '0;
      idx_q    <= '0;
      write_q  <= 1'b0;
      victim_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          tag_q   <= req_addr_i[ADDR_W-1 -: TAG_W];
          idx_q   <= req_addr_i[OFF_W +: IDX_W];
          write_q <= req_write_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            state_q <= ST_IDLE;
          end else begin
            victim_q <= victim;
            state_q  <= (rd_valid[victim] && rd_dirty[victim]) ? ST_WB : ST_FILL;
          end
        end
        ST_WB:   if (wb_ack_i)   state_q <= ST_FILL;
        ST_FILL: if (fill_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = state_q == ST_IDLE;
  assign resp_valid_o = (in_lookup && hit) || install;
  assign resp_hit_o   = in_lookup;
  assign resp_way_o   = in_lookup ? hit_way : victim_q;
  assign wb_valid_o   = state_q == ST_WB;
  assign wb_tag_o     = rd_tag[victim_q];
  assign wb_index_o   = idx_q;
  assign fill_valid_o = state_q == ST_FILL;
  assign fill_tag_o   = tag_q;
  assign fill_index_o = idx_q;
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int TAG_W = 24,
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             resp_valid_o,
  input logic             resp_hit_o,
  input logic             wb_valid_o,
  input logic             wb_ack_i,
  input logic [TAG_W-1:0] wb_tag_o,
  input logic [IDX_W-1:0] wb_index_o,
  input logic             fill_valid_o,
  input logic             fill_ack_i,
  input logic [TAG_W-1:0] fill_tag_o
);
  assert_wb_fill_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_valid_o && fill_valid_o));

  assert_wb_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ack_i |=> wb_valid_o && $stable(wb_tag_o) && $stable(wb_index_o));

  assert_fill_after_wb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_ack_i |=> fill_valid_o);

  assert_fill_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o && !fill_ack_i |=> fill_valid_o && $stable(fill_tag_o));

  assert_fill_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o && fill_ack_i |-> resp_valid_o && !resp_hit_o);

  assert_one_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_busy_no_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o || wb_valid_o || fill_valid_o) |-> !req_ready_o);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/cache_tag_ctrl_test.sv
module cache_tag_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [35:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        resp_valid_o, resp_hit_o;
  logic [2:0]  resp_way_o;
  logic        wb_valid_o;
  logic        wb_ack_i = 1'b0;
  logic [23:0] wb_tag_o;
  logic [5:0]  wb_index_o;
  logic        fill_valid_o;
  logic        fill_ack_i = 1'b0;
  logic [23:0] fill_tag_o;
  logic [5:0]  fill_index_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  cache_tag_ctrl uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one request; checks lookup, optional write-back and fill phases
  task automatic access(input logic [5:0] idx, input logic [23:0] tag, input logic [5:0] off,
                        input bit wr, input bit exp_hit, input logic [2:0] exp_way,
                        input bit exp_wb, input logic [23:0] exp_wb_tag, input string req);
    @(negedge clk_i);
    chk("R8", "ready idle", 32'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_addr_i  = {tag, idx, off};
    req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R8", "ready busy", 32'(req_ready_o), 0);
    if (exp_hit) begin
      chk(req, "hit resp_valid", 32'(resp_valid_o), 1);
      chk(req, "hit resp_hit", 32'(resp_hit_o), 1);
      chk(req, "hit way", 32'(resp_way_o), 32'(exp_way));
      return;
    end
    chk(req, "miss no resp", 32'(resp_valid_o), 0);
    @(negedge clk_i);
    if (exp_wb) begin
      chk("R6", "wb_valid", 32'(wb_valid_o), 1);
      chk("R6", "no early fill", 32'(fill_valid_o), 0);
      chk("R6", "wb_tag", 32'(wb_tag_o), 32'(exp_wb_tag));
      chk("R6", "wb_index", 32'(wb_index_o), 32'(idx));
      @(negedge clk_i);
      chk("R6", "wb held", 32'(wb_valid_o), 1);
      chk("R6", "fill waits ack", 32'(fill_valid_o), 0);
      wb_ack_i = 1'b1;
      @(negedge clk_i);
      wb_ack_i = 1'b0;
    end else begin
      chk("R7", "no wb clean victim", 32'(wb_valid_o), 0);
    end
    chk("R7", "fill_valid", 32'(fill_valid_o), 1);
    chk("R7", "fill_tag", 32'(fill_tag_o), 32'(tag));
    chk("R7", "fill_index", 32'(fill_index_o), 32'(idx));
    fill_ack_i = 1'b1;
    #1;
    chk("R7", "miss resp_valid", 32'(resp_valid_o), 1);
    chk("R7", "miss resp_hit", 32'(resp_hit_o), 0);
    chk(req, "victim way", 32'(resp_way_o), 32'(exp_way));
    @(negedge clk_i);
    fill_ack_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9", "ready", 32'(req_ready_o), 1);
    chk("R9", "resp_valid", 32'(resp_valid_o), 0);
    chk("R9", "wb_valid", 32'(wb_valid_o), 0);
    chk("R9", "fill_valid", 32'(fill_valid_o), 0);
  endtask

  // set 5 via 4096-byte aliases: in-order fill, offset-blind hit, LRU eviction
  task automatic t_lru_set();
    for (int k = 0; k < 8; k++)
      access(6'd5, 24'(100 + k), 6'd0, 1'b0, 1'b0, 3'(k), 1'b0, '0, "R3");
    access(6'd5, 24'd103, 6'h2c, 1'b0, 1'b1, 3'd3, 1'b0, '0, "R1");
    access(6'd5, 24'd200, 6'd0, 1'b0, 1'b0, 3'd0, 1'b0, '0, "R4");
    access(6'd5, 24'd101, 6'd7, 1'b0, 1'b1, 3'd1, 1'b0, '0, "R2");
    access(6'd5, 24'd201, 6'd0, 1'b0, 1'b0, 3'd2, 1'b0, '0, "R4");
    access(6'd5, 24'd100, 6'd0, 1'b0, 1'b0, 3'd4, 1'b0, '0, "R4");
  endtask

  // set 12: write hit makes line dirty, later evicted with write-back
  task automatic t_write_hit_dirty();
    access(6'd12, 24'd300, 6'd0, 1'b0, 1'b0, 3'd0, 1'b0, '0, "R3");
    access(6'd12, 24'd300, 6'd4, 1'b1, 1'b1, 3'd0, 1'b0, '0, "R5");
    for (int k = 1; k < 8; k++)
      access(6'd12, 24'(300 + k), 6'd0, 1'b0, 1'b0, 3'(k), 1'b0, '0, "R3");
    access(6'd12, 24'd400, 6'd0, 1'b0, 1'b0, 3'd0, 1'b1, 24'd300, "R6");
    // way 1 was only read: clean eviction
    access(6'd12, 24'd401, 6'd0, 1'b0, 1'b0, 3'd1, 1'b0, '0, "R5");
  endtask

  // set 9: write miss installs dirty
  task automatic t_write_miss_dirty();
    access(6'd9, 24'h00abcd, 6'd0, 1'b1, 1'b0, 3'd0, 1'b0, '0, "R5");
    for (int k = 1; k < 8; k++)
      access(6'd9, 24'(500 + k), 6'd0, 1'b0, 1'b0, 3'(k), 1'b0, '0, "R3");
    access(6'd9, 24'd600, 6'd0, 1'b0, 1'b0, 3'd0, 1'b1, 24'h00abcd, "R5");
  endtask

  task automatic t_reset_clears();
    do_reset();
    t_reset_state();
    access(6'd5, 24'd101, 6'd0, 1'b0, 1'b0, 3'd0, 1'b0, '0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    @(negedge clk_i);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_lru_set();
    t_write_hit_dirty();
    t_write_miss_dirty();
    t_reset_clears();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule